// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block keeps the program-counter sequence for an in-order core whose branches have a delay slot. It holds three addresses. `pc` is the instruction being retired. `npc` is the instruction after it, which for a branch is the delay slot. `nnpc` is the address that follows `npc`. Each `advance` strobe retires the instruction at `pc` and moves the chain forward by one step.

The decode stage supplies the 32-bit instruction word and a format select that says how to extract the displacement. The condition logic supplies the `taken` flag and the annul bit. From these the unit forms the branch target relative to `pc` and decides what follows the delay slot.

Annulment works by marking a slot, not by removing it. When a branch is annulled, its delay slot still passes through `pc`, but `squash` is raised so the core discards that slot. The slot's own branch fields are then ignored.

Top module: `dbr_next_pc`

## Requirements
- R1: A synchronous reset with `rst` high sets `pc` to RESET_VEC, `npc` to RESET_VEC+4 and `nnpc` to RESET_VEC+8, and clears `squash`.
- R2: While `advance` is low, `pc`, `npc`, `nnpc` and `squash` keep their values.
- R3: A sequential advance moves `pc` to old `npc`, moves `npc` to old `nnpc`, sets `nnpc` to the new `npc`+4 and clears `squash`. The addresses wrap modulo 2^32.
- R4: Three plain formats form the displacement as sign-extend({field, 2'b00}): code 1 uses field insn[29:0], code 2 uses insn[21:0] and code 3 uses insn[18:0].
- R5: Format code 4 is the split format. Its displacement is sign-extend18({insn[21:20], insn[13:0], 2'b00}).
- R6: Format code 5 uses the immediate form. Its displacement is sign-extend(insn[12:0]) with no shift.
- R7: On advance with a branch format, `taken` high and `annul` low, `pc` becomes old `npc` (the delay slot), `npc` becomes the target, `nnpc` becomes target+4, and `squash` stays low.
- R8: On advance with a branch format, `annul` high and `taken` low, `pc` becomes old `npc`, `npc` becomes old `npc`+4, `nnpc` becomes old `npc`+8, and `squash` goes high.
- R9: On advance with a branch format and both `taken` and `annul` high, `pc` becomes old `npc`, `npc` becomes the target, `nnpc` becomes target+4, and `squash` goes high.
- R10: `squash` stays high for exactly one advance. On that advance the word's format, `taken` and `annul` are ignored, and the step is sequential.
- R11: `tgt` always equals `pc` plus the displacement of the current format, modulo 2^32. Backward displacements give lower addresses.
- R12: Format codes 0, 6 and 7 are not branches. With any of them, `taken` and `annul` have no effect and `tgt` equals `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Retire the instruction at `pc` and step the chain |
| insn | input | 32 | Instruction word at `pc` |
| fmt | input | 3 | Displacement format select (0 none, 1..5 branch formats) |
| taken | input | 1 | Branch condition result |
| annul | input | 1 | Annul bit of the branch |
| pc | output | 32 | Current instruction address |
| npc | output | 32 | Next address (delay slot after a branch) |
| nnpc | output | 32 | Address after `npc` |
| tgt | output | 32 | Branch target for the current word |
| squash | output | 1 | Instruction at `pc` is an annulled delay slot |

## Verification
The bench targets sign extension at each field's top bit, negative displacements and address wrap past 0xFFFFFFFC. A unit that extends from the wrong bit sends backward branches far forward. A unit that splits the 16-bit field at the wrong place gives targets off by multiples of 4 or 65536. It also checks that an annulled slot still passes through `pc` with `squash` set and that a branch word sitting in a squashed slot is ignored. A unit that lets that word redirect fetch, or keeps `squash` high for a second advance, shows the wrong `npc` or `squash` on the following steps. Held cycles with `advance` low catch a chain that moves on its own.

// File: rtl/dbr_next_pc.sv
module dbr_next_pc #(
  parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        advance,
  input  logic [31:0] insn,
  input  logic [2:0]  fmt,
  input  logic        taken,
  input  logic        annul,
  output logic [31:0] pc,
  output logic [31:0] npc,
  output logic [31:0] nnpc,
  output logic [31:0] tgt,
  output logic        squash
);

  localparam logic [2:0] F_D30 = 3'd1;
  localparam logic [2:0] F_D22 = 3'd2;
  localparam logic [2:0] F_D19 = 3'd3;
  localparam logic [2:0] F_D16 = 3'd4;
  localparam logic [2:0] F_I13 = 3'd5;

  logic [31:0] disp, nxt_npc;
  logic        is_br, go, kill;

  always_comb begin
    case (fmt)
      F_D30:   disp = {insn[29:0], 2'b00};
      F_D22:   disp = {{8{insn[21]}}, insn[21:0], 2'b00};
      F_D19:   disp = {{11{insn[18]}}, insn[18:0], 2'b00};
      F_D16:   disp = {{14{insn[21]}}, insn[21:20], insn[13:0], 2'b00};
      F_I13:   disp = {{19{insn[12]}}, insn[12:0]};
      default: disp = '0;
    endcase
  end

  assign tgt     = pc + disp;
  assign is_br   = (fmt >= F_D30) && (fmt <= F_I13) && !squash;
  assign go      = is_br && taken;
  assign kill    = is_br && annul;
  assign nxt_npc = go ? tgt : (kill ? npc + 32'd4 : nnpc);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= RESET_VEC;
      npc    <= RESET_VEC + 32'd4;
      nnpc   <= RESET_VEC + 32'd8;
      squash <= 1'b0;
    end else if (advance) begin
      pc     <= npc;
      npc    <= nxt_npc;
      nnpc   <= nxt_npc + 32'd4;
      squash <= kill;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(pc) && $stable(npc) && $stable(nnpc) && $stable(squash));

  p_shift_r3: assert property (@(posedge clk) disable iff (rst)
    advance |=> pc == $past(npc));

  p_taken_r7: assert property (@(posedge clk) disable iff (rst)
    advance && !squash && fmt >= 3'd1 && fmt <= 3'd5 && taken && !annul
    |=> npc == $past(tgt) && !squash);

  p_annul_r8: assert property (@(posedge clk) disable iff (rst)
    advance && !squash && fmt >= 3'd1 && fmt <= 3'd5 && annul && !taken
    |=> npc == $past(npc) + 32'd4 && squash);

  p_once_r10: assert property (@(posedge clk) disable iff (rst)
    squash && advance |=> !squash);

  p_nobr_r12: assert property (@(posedge clk) disable iff (rst)
    (fmt == 3'd0 || fmt > 3'd5) |-> tgt == pc);

endmodule

// File: tb/dbr_next_pc_tb.sv
`timescale 1ns/1ps
module dbr_next_pc_tb;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic clk = 1'b0, rst = 1'b1, advance = 1'b0, taken = 1'b0, annul = 1'b0;
  logic [31:0] insn = '0;
  logic [2:0]  fmt = '0;
  logic [31:0] pc, npc, nnpc, tgt;
  logic        squash;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_pc, m_npc, m_nnpc;
  logic        m_sq;

  always #2.5 clk = ~clk;

  dbr_next_pc #(.RESET_VEC(RV)) u_dut (
    .clk(clk), .rst(rst), .advance(advance), .insn(insn), .fmt(fmt),
    .taken(taken), .annul(annul), .pc(pc), .npc(npc), .nnpc(nnpc),
    .tgt(tgt), .squash(squash));

  function automatic logic [31:0] exp_disp(input logic [2:0] f, input logic [31:0] w);
    logic signed [31:0] s;
    case (f)
      3'd1: s = $signed({w[29:0], 2'b00});
      3'd2: s = $signed({w[21:0], 2'b00, 8'h00}) >>> 8;
      3'd3: s = $signed({w[18:0], 2'b00, 11'h000}) >>> 11;
      3'd4: s = $signed({w[21:20], w[13:0], 2'b00, 14'h0000}) >>> 14;
      3'd5: s = $signed({w[12:0], 19'h00000}) >>> 19;
      default: s = 0;
    endcase
    return s;
  endfunction

  function automatic string fmt_req(input logic [2:0] f);
    if (f >= 3'd1 && f <= 3'd3) return "R4";
    if (f == 3'd4) return "R5";
    if (f == 3'd5) return "R6";
    return "R12";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " pc"}, pc, m_pc);
    chk({req, " npc"}, npc, m_npc);
    chk({req, " nnpc"}, nnpc, m_nnpc);
    chk({req, " squash"}, {31'b0, squash}, {31'b0, m_sq});
  endtask

  task automatic step(input logic adv, input logic [2:0] f, input logic [31:0] w,
                      input logic tk, input logic an);
    logic [31:0] t, nn;
    logic br, kill;
    string req;
    @(negedge clk);
    advance = adv; fmt = f; insn = w; taken = tk; annul = an;
    #1;
    t = m_pc + exp_disp(f, w);
    chk({fmt_req(f), " R11 tgt"}, tgt, t);
    br = (f >= 3'd1 && f <= 3'd5) && !m_sq;
    kill = br && an;
    if (!adv) req = "R2";
    else if (m_sq) req = "R10";
    else if (!br) req = (f == 3'd0) ? "R3" : "R12";
    else if (tk && an) req = "R9";
    else if (tk) req = "R7";
    else if (an) req = "R8";
    else req = "R3";
    if (adv) begin
      nn = (br && tk) ? t : (kill ? m_npc + 32'd4 : m_nnpc);
      m_pc = m_npc; m_npc = nn; m_nnpc = nn + 32'd4; m_sq = kill;
    end
    @(posedge clk); #1;
    chk_state(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    m_pc = RV; m_npc = RV + 4; m_nnpc = RV + 8; m_sq = 0;
    chk_state("R1");
    @(negedge clk); rst = 0;
    step(0, 3'd1, 32'h0000_0010, 1, 1);             // R2 hold
    step(1, 3'd0, 32'hFFFF_FFFF, 1, 1);             // R12 no branch
    step(1, 3'd6, 32'h1234_5678, 1, 1);             // R12
    step(1, 3'd2, 32'h003F_FFFF, 1, 0);             // R4 backward -4, R7
    step(1, 3'd3, 32'h0004_0000, 0, 1);             // R4 d19 min, R8 annul untaken
    step(1, 3'd1, 32'h0000_0040, 1, 0);             // R10 squashed slot ignored
    step(1, 3'd4, 32'h0020_0001, 1, 1);             // R5 split negative, R9
    step(1, 3'd5, 32'h0000_1FFF, 1, 0);             // R10 then R6 next
    step(1, 3'd5, 32'h0000_1000, 1, 0);             // R6 min imm
    step(1, 3'd1, (32'hFFFF_FFF8 - m_pc) >> 2, 1, 0); // R3 wrap setup
    step(1, 3'd0, 32'h0, 0, 0);
    step(1, 3'd0, 32'h0, 0, 0);                     // R3 wraps past top
    step(1, 3'd0, 32'h0, 0, 0);
    for (int i = 0; i < 4000; i++)
      step(($urandom % 8) != 0, 3'($urandom % 8), $urandom,
           1'($urandom % 2), 1'($urandom % 3 == 0));
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    m_pc = RV; m_npc = RV + 4; m_nnpc = RV + 8; m_sq = 0;
    chk_state("R1");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule